// File: doc/BRIEF.md
# Two-Source Prioritized Interrupt Controller

This block arbitrates interrupts for a small microcontroller core that has two timer-overflow sources. It keeps one 8-bit control register that holds a global enable, one enable per source and one sticky request flag per source. Software reads and writes this register over a plain register-bus port. A timer overflow pulse sets its source's flag whether or not that source is enabled. The flag then stays set until the source is serviced or software writes it to zero.

Requests are evaluated only in a cycle where the phase strobe `t2_stb` is high. In that cycle the controller looks at the current register contents and the core's return-stack-full indication. When a source qualifies, the controller issues a one-cycle `irq_take` pulse with a fixed vector in the next cycle. The core uses that pulse to push its program counter, to branch, and to leave a halted state. Servicing clears the global enable, so nesting is blocked until software sets it again or the core signals a return-from-interrupt. The stack, the timers and the instruction decoder are outside the block.

Top module: `tmr_irq_ctrl`

## Requirements
- R1: After a synchronous active-low reset, every control register bit reads 0 and `irq_take` is low.
- R2: Register layout: bit 0 is the global enable, bit 2 is the source-0 enable, bit 3 is the source-1 enable, bit 5 is the source-0 flag and bit 6 is the source-1 flag. A write replaces these five bits. Bits 1, 4 and 7 always read 0, and writing 1 to them has no effect.
- R3: A one-cycle overflow pulse sets its source's flag in the next cycle, whatever the enables are. The flag stays set until the source is serviced or software writes 0 to it.
- R4: A source is taken only in a strobe cycle where the global enable, its own enable and its flag are all 1 and `stk_full` is low. `irq_take` rises in the cycle after that strobe cycle and lasts one cycle.
- R5: A flag that becomes set between strobes is not serviced before the next strobe. An overflow pulse that arrives in the same cycle as a strobe waits for the following strobe.
- R6: When both sources qualify in the same strobe cycle, source 0 wins. The vector is 08h for source 0 and 0Ch for source 1, and it is valid while `irq_take` is high.
- R7: On a take, the flag of the serviced source and the global enable read 0 in the next cycle. The other source's flag and both per-source enables are left unchanged.
- R8: A `reti` pulse sets the global enable. A `ret` pulse leaves the global enable unchanged.
- R9: An overflow pulse that coincides with a software write of 0 to its flag, or with the servicing of that same source, leaves the flag set.
- R10: While `stk_full` is high at a strobe, no take occurs and the flags stay pending. A later strobe with the stack not full services them.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Synchronous active-low reset |
| t2_stb | input | 1 | Phase strobe; requests are evaluated in cycles where it is high |
| tmr0_ovf | input | 1 | Source 0 overflow pulse |
| tmr1_ovf | input | 1 | Source 1 overflow pulse |
| stk_full | input | 1 | Core return stack is full |
| reti | input | 1 | Core executed return-from-interrupt |
| ret | input | 1 | Core executed plain return |
| reg_wr | input | 1 | Control register write strobe |
| reg_wdata | input | 8 | Control register write data |
| reg_rdata | output | 8 | Control register read data |
| irq_take | output | 1 | One-cycle take pulse (push PC, branch, wake) |
| irq_vec | output | 8 | Vector address of the taken source |

## Verification
The bench builds the block with its default parameters: an 8-bit register, 8-bit vectors, and vectors 08h and 0Ch. These values make every bit position and both vector codes visible at the ports. The bench can therefore check priority, clear-on-service and the reserved bits by their exact values. Because both sources are present, simultaneous requests reach the priority logic, and a losing source can be seen to stay pending in the register.

// File: rtl/intc_pkg.sv
// Shared constants for the two-source interrupt controller.
// Assumes an 8-bit control register; the bit positions are
// software-visible and must not move.
package intc_pkg;
    localparam int REG_W  = 8;
    localparam int NSRC   = 2;
    localparam int BIT_ME = 0;

    // Enable bit position of source i
    function automatic int en_pos(input int i);
        return (i == 0) ? 2 : 3;
    endfunction

    // Request flag bit position of source i
    function automatic int fl_pos(input int i);
        return (i == 0) ? 5 : 6;
    endfunction
endpackage

// File: rtl/intc_ctlreg.sv
// Control register: global enable, per-source enables and sticky flags.
// Assumes svc is one-hot-or-zero and that it is only asserted while the
// global enable is set. Flag priority: hardware set > service clear >
// software write. Global enable: service clear > reti > software write.
module intc_ctlreg
    import intc_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wdata,
    input  logic [NSRC-1:0]  hw_set,
    input  logic [NSRC-1:0]  svc,
    input  logic             reti,
    output logic [REG_W-1:0] rdata,
    output logic             me,
    output logic [NSRC-1:0]  en,
    output logic [NSRC-1:0]  flag
);
    logic            me_q;
    logic [NSRC-1:0] en_q;
    logic [NSRC-1:0] flag_q;

    // Global enable: cleared on service, set on reti, else software write
    always_ff @(posedge clk) begin
        if (!rst_n)          me_q <= 1'b0;
        else if (|svc)       me_q <= 1'b0;
        else if (reti)       me_q <= 1'b1;
        else if (wr_en)      me_q <= wdata[BIT_ME];
    end

    for (genvar i = 0; i < NSRC; i++) begin : g_src
        // Per-source enable: software write only
        always_ff @(posedge clk) begin
            if (!rst_n)      en_q[i] <= 1'b0;
            else if (wr_en)  en_q[i] <= wdata[en_pos(i)];
        end

        // Sticky flag: overflow sets, service or software clears
        always_ff @(posedge clk) begin
            if (!rst_n)          flag_q[i] <= 1'b0;
            else if (hw_set[i])  flag_q[i] <= 1'b1;
            else if (svc[i])     flag_q[i] <= 1'b0;
            else if (wr_en)      flag_q[i] <= wdata[fl_pos(i)];
        end

        // R3
        flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
            hw_set[i] |=> flag_q[i]);
    end

    // Read image: reserved bits are zero
    always_comb begin
        rdata = '0;
        rdata[BIT_ME] = me_q;
        for (int i = 0; i < NSRC; i++) begin
            rdata[en_pos(i)] = en_q[i];
            rdata[fl_pos(i)] = flag_q[i];
        end
    end

    assign me   = me_q;
    assign en   = en_q;
    assign flag = flag_q;

    // R7
    me_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|svc) |=> !me_q);
endmodule

// File: rtl/intc_arbiter.sv
// Strobe-gated priority arbiter. Evaluates requests only when strobe is
// high and the stack is not full; the lowest index wins. The take pulse
// and vector are registered, so they appear one cycle after the strobe.
module intc_arbiter
    import intc_pkg::*;
#(
    parameter int VEC_W = 8,
    parameter logic [NSRC-1:0][VEC_W-1:0] VECS = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             strobe,
    input  logic             stk_full,
    input  logic             me,
    input  logic [NSRC-1:0]  en,
    input  logic [NSRC-1:0]  flag,
    output logic [NSRC-1:0]  svc,
    output logic             take,
    output logic [VEC_W-1:0] vec
);
    logic [NSRC-1:0]  req;
    logic [NSRC-1:0]  grant;
    logic [VEC_W-1:0] vec_nxt;
    logic             take_q;
    logic [VEC_W-1:0] vec_q;

    // Qualify each source at the strobe
    assign req = flag & en & {NSRC{me & strobe & ~stk_full}};

    // Fixed priority: first qualifying index wins
    always_comb begin
        grant   = '0;
        vec_nxt = '0;
        for (int i = NSRC - 1; i >= 0; i--) begin
            if (req[i]) begin
                grant   = '0;
                grant[i] = 1'b1;
                vec_nxt = VECS[i];
            end
        end
    end

    // Register the take pulse and hold the vector of the last take
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            take_q <= 1'b0;
            vec_q  <= '0;
        end else begin
            take_q <= |grant;
            if (|grant) vec_q <= vec_nxt;
        end
    end

    assign svc  = grant;
    assign take = take_q;
    assign vec  = vec_q;

    // R10
    stack_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stk_full |=> !take_q);

    // R4
    take_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        take_q |=> !take_q);

    // R5
    take_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        take_q |-> $past(strobe));

    // R6
    prio_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe && me && en[0] && flag[0] && !stk_full)
            |=> (take_q && vec_q == VECS[0]));
endmodule

// File: rtl/tmr_irq_ctrl.sv
// Top of the two-source interrupt controller. Joins the control register
// and the arbiter. Assumes overflow, reti and ret inputs are one-cycle
// pulses synchronous to clk, and that t2_stb marks the evaluation phase.
module tmr_irq_ctrl
    import intc_pkg::*;
#(
    parameter int VEC_W = 8,
    parameter logic [VEC_W-1:0] VEC_T0 = 8'h08,
    parameter logic [VEC_W-1:0] VEC_T1 = 8'h0C
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             t2_stb,
    input  logic             tmr0_ovf,
    input  logic             tmr1_ovf,
    input  logic             stk_full,
    input  logic             reti,
    input  logic             ret,
    input  logic             reg_wr,
    input  logic [REG_W-1:0] reg_wdata,
    output logic [REG_W-1:0] reg_rdata,
    output logic             irq_take,
    output logic [VEC_W-1:0] irq_vec
);
    localparam logic [NSRC-1:0][VEC_W-1:0] VECS = {VEC_T1, VEC_T0};

    logic            me;
    logic [NSRC-1:0] en;
    logic [NSRC-1:0] flag;
    logic [NSRC-1:0] svc;

    intc_ctlreg u_reg (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (reg_wr),
        .wdata  (reg_wdata),
        .hw_set ({tmr1_ovf, tmr0_ovf}),
        .svc    (svc),
        .reti   (reti),
        .rdata  (reg_rdata),
        .me     (me),
        .en     (en),
        .flag   (flag)
    );

    intc_arbiter #(
        .VEC_W (VEC_W),
        .VECS  (VECS)
    ) u_arb (
        .clk      (clk),
        .rst_n    (rst_n),
        .strobe   (t2_stb),
        .stk_full (stk_full),
        .me       (me),
        .en       (en),
        .flag     (flag),
        .svc      (svc),
        .take     (irq_take),
        .vec      (irq_vec)
    );

    // R8
    ret_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ret && !reti && !reg_wr && !(|svc)) |=> (me == $past(me)));

    // R8
    reti_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reti && !(|svc)) |=> me);
endmodule

// File: tb/tmr_irq_ctrl_test.sv
module tmr_irq_ctrl_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       t2_stb = 1'b0;
    logic       tmr0_ovf = 1'b0;
    logic       tmr1_ovf = 1'b0;
    logic       stk_full = 1'b0;
    logic       reti = 1'b0;
    logic       ret = 1'b0;
    logic       reg_wr = 1'b0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic       irq_take;
    logic [7:0] irq_vec;

    int n_tests = 0;
    int n_fail  = 0;

    always #4 clk = ~clk;

    tmr_irq_ctrl uut (
        .clk(clk), .rst_n(rst_n), .t2_stb(t2_stb),
        .tmr0_ovf(tmr0_ovf), .tmr1_ovf(tmr1_ovf), .stk_full(stk_full),
        .reti(reti), .ret(ret), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .irq_take(irq_take), .irq_vec(irq_vec)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic cyc();
        @(negedge clk);
    endtask

    task automatic wr(input logic [7:0] d);
        reg_wr = 1'b1; reg_wdata = d;
        cyc();
        reg_wr = 1'b0;
    endtask

    task automatic pulse(input logic t0, input logic t1);
        tmr0_ovf = t0; tmr1_ovf = t1;
        cyc();
        tmr0_ovf = 1'b0; tmr1_ovf = 1'b0;
    endtask

    task automatic strobe(input logic t0, input logic t1, input logic sf,
                          output logic took, output logic [7:0] v);
        t2_stb = 1'b1; tmr0_ovf = t0; tmr1_ovf = t1; stk_full = sf;
        cyc();
        t2_stb = 1'b0; tmr0_ovf = 1'b0; tmr1_ovf = 1'b0; stk_full = 1'b0;
        took = irq_take; v = irq_vec;
    endtask

    task automatic t_reset();
        chk("R1 reg after reset", reg_rdata, 8'h00);
        chk("R1 take after reset", {7'b0, irq_take}, 8'h00);
    endtask

    task automatic t_layout();
        wr(8'hFF);
        chk("R2 writable bits only", reg_rdata, 8'h6D);
        wr(8'h92);
        chk("R2 reserved bits ignored", reg_rdata, 8'h00);
        wr(8'h24);
        chk("R2 flag0/en0 positions", reg_rdata, 8'h24);
        wr(8'h00);
    endtask

    task automatic t_sticky();
        logic took; logic [7:0] v;
        pulse(1'b1, 1'b0);
        chk("R3 flag set while disabled", reg_rdata, 8'h20);
        repeat (4) cyc();
        chk("R3 flag sticky", reg_rdata, 8'h20);
        strobe(1'b0, 1'b0, 1'b0, took, v);
        chk("R4 no take without enables", {7'b0, took}, 8'h00);
        wr(8'h00);
        chk("R3 software clear", reg_rdata, 8'h00);
    endtask

    task automatic t_service0();
        logic took; logic [7:0] v;
        wr(8'h05);
        pulse(1'b1, 1'b0);
        chk("R3 flag set", reg_rdata, 8'h25);
        for (int i = 0; i < 3; i++) begin
            cyc();
            chk("R5 no take between strobes", {7'b0, irq_take}, 8'h00);
        end
        strobe(1'b0, 1'b0, 1'b0, took, v);
        chk("R4 take after strobe", {7'b0, took}, 8'h01);
        chk("R6 vector source0", v, 8'h08);
        chk("R7 flag and ME cleared", reg_rdata, 8'h04);
        cyc();
        chk("R4 take one cycle", {7'b0, irq_take}, 8'h00);
    endtask

    task automatic t_priority();
        logic took; logic [7:0] v;
        wr(8'h0D);
        pulse(1'b1, 1'b1);
        chk("R3 both flags", reg_rdata, 8'h6D);
        strobe(1'b0, 1'b0, 1'b0, took, v);
        chk("R6 source0 wins", v, 8'h08);
        chk("R7 other flag kept", reg_rdata, 8'h4C);
        strobe(1'b0, 1'b0, 1'b0, took, v);
        chk("R7 no nesting with ME clear", {7'b0, took}, 8'h00);
        reti = 1'b1; cyc(); reti = 1'b0;
        chk("R8 reti sets ME", reg_rdata, 8'h4D);
        strobe(1'b0, 1'b0, 1'b0, took, v);
        chk("R6 source1 taken", {7'b0, took}, 8'h01);
        chk("R6 vector source1", v, 8'h0C);
        chk("R7 source1 cleared", reg_rdata, 8'h0C);
    endtask

    task automatic t_ret();
        ret = 1'b1; cyc(); ret = 1'b0;
        chk("R8 ret keeps ME clear", reg_rdata, 8'h0C);
        wr(8'h0D);
        ret = 1'b1; cyc(); ret = 1'b0;
        chk("R8 ret keeps ME set", reg_rdata, 8'h0D);
    endtask

    task automatic t_enable();
        logic took; logic [7:0] v;
        wr(8'h09);
        pulse(1'b1, 1'b0);
        strobe(1'b0, 1'b0, 1'b0, took, v);
        chk("R4 disabled source not taken", {7'b0, took}, 8'h00);
        chk("R4 state unchanged", reg_rdata, 8'h29);
        wr(8'h00);
    endtask

    task automatic t_stack();
        logic took; logic [7:0] v;
        wr(8'h05);
        pulse(1'b1, 1'b0);
        strobe(1'b0, 1'b0, 1'b1, took, v);
        chk("R10 no take while stack full", {7'b0, took}, 8'h00);
        chk("R10 request pending", reg_rdata, 8'h25);
        strobe(1'b0, 1'b0, 1'b0, took, v);
        chk("R10 taken after stack frees", {7'b0, took}, 8'h01);
        chk("R10 vector", v, 8'h08);
    endtask

    task automatic t_race();
        logic took; logic [7:0] v;
        wr(8'h40);
        reg_wr = 1'b1; reg_wdata = 8'h00; tmr1_ovf = 1'b1;
        cyc();
        reg_wr = 1'b0; tmr1_ovf = 1'b0;
        chk("R9 set beats software clear", reg_rdata, 8'h40);
        wr(8'h05);
        pulse(1'b1, 1'b0);
        strobe(1'b1, 1'b0, 1'b0, took, v);
        chk("R9 take during new overflow", {7'b0, took}, 8'h01);
        chk("R9 set beats service clear", reg_rdata, 8'h24);
    endtask

    task automatic t_coincident();
        logic took; logic [7:0] v;
        wr(8'h05);
        strobe(1'b1, 1'b0, 1'b0, took, v);
        chk("R5 overflow at strobe waits", {7'b0, took}, 8'h00);
        chk("R5 flag recorded", reg_rdata, 8'h25);
        strobe(1'b0, 1'b0, 1'b0, took, v);
        chk("R5 serviced at next strobe", {7'b0, took}, 8'h01);
    endtask

    initial begin
        repeat (3) cyc();
        rst_n = 1'b1;
        cyc();
        t_reset();
        t_layout();
        t_sticky();
        t_service0();
        t_priority();
        t_ret();
        t_enable();
        t_stack();
        t_race();
        t_coincident();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        #800000;
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule